// File: doc/BRIEF.md
# Deep Sleep Wake Controller

This block controls when a system clock domain enters and leaves a low-power deep sleep state. Software arms it by setting an enable bit and loading a 16-bit wake count. An external active-low sleep request pin is then sampled through a synchronizer. When the request is seen low with the enable bit set, a fixed three-cycle shutdown sequence runs, and at its end the downstream clock is gated off. The gate is modelled as an enable output.

When the request pin returns high, a wake counter advances once per oscillator cycle. It pauses whenever the pin is low again. When the counter reaches the programmed count, the gate enable is raised and a completion flag is set. While the enable bit stays set, a fresh low request puts the block back to sleep. Clearing the enable bit returns it to idle.

The whole block runs on the raw oscillator clock, which is also the reference clock for the shutdown sequence. The clock is free-running throughout.

Top module: `dslp_wake_ctrl`

## Requirements
- R1: After reset, `clk_gate_en` is 1, `wake_done` is 0, and both registers read back as zero.
- R2: While the enable bit is 0, a low request never gates the clock.
- R3: With the enable bit set, a request pin driven low just before rising edge 1 drops `clk_gate_en` on rising edge 6. That is two synchronizer stages, one decision cycle and three shutdown cycles.
- R4: Once shutdown has begun, releasing the pin before it ends does not stop the clock from being gated.
- R5: With wake count N ≥ 1 and the pin high from just before edge 1, `clk_gate_en` rises on edge N+2 and stays 0 until then.
- R6: A wake count of 0 behaves as 1, so the clock returns on edge 3 after release.
- R7: A low request during counting holds the wake count without clearing it. Counting resumes where it stopped, and the gate stays off throughout.
- R8: `wake_done` is set on the same edge that `clk_gate_en` rises. It reads as bit 1 of address 0. Writing 1 to that bit clears it.
- R9: In the awake state with the enable bit still set, a new low request repeats the shutdown and gates the clock again, even while `wake_done` is set.
- R10: Clearing the enable bit while awake returns the block to idle. Later low requests are then ignored.
- R11: Address 0 holds the enable in bit 0 (read/write) and the completion flag in bit 1. Address 1 holds the 16-bit wake count. `reg_rdata` shows the register selected by `reg_addr` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock, also the shutdown reference |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 wake count |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| sleep_req_n | input | 1 | Asynchronous active-low sleep request |
| clk_gate_en | output | 1 | Downstream clock enable, 1 = clock passes |
| wake_done | output | 1 | Completion flag, set on wake |

## Verification
The bound assertions check four things on every cycle:
- the gate only falls directly out of shutdown;
- shutdown always finishes into the asleep state;
- the wake counter is frozen while the request is low during counting;
- the gate stays off while waiting, and every gate rise comes with the completion flag.

They also check that a disabled idle block stays idle and that clearing the enable while awake leads to idle. Exact latencies need the bench's directed scenarios: the edge-6 fall, the N+2 rise, and the zero count acting as one. So do the early-release shutdown, the resumed count after an interruption, the re-entry with the flag still set, and the register read-back and write-one-to-clear.

// File: rtl/dslp_pkg.sv
package dslp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHUTDOWN,
    ST_ASLEEP,
    ST_COUNTING,
    ST_AWAKE
  } dslp_state_e;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_WCNT = 1'b1;
  localparam int   CTRL_EN_BIT   = 0;
  localparam int   CTRL_DONE_BIT = 1;
endpackage

// File: rtl/dslp_sync.sv
module dslp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= {STAGES{RST_VAL}};
    else     shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/dslp_regs.sv
module dslp_regs
  import dslp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              set_done,
  output logic              sleep_en,
  output logic              done,
  output logic [CNT_W-1:0]  cnt_cfg
);
  logic [DATA_W-1:0] ctrl_word;
  logic              wr_ctrl;
  logic              wr_wcnt;

  assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
  assign wr_wcnt = wr_en && (addr == ADDR_WCNT);

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_EN_BIT]   = sleep_en;
    ctrl_word[CTRL_DONE_BIT] = done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_en <= 1'b0;
      done     <= 1'b0;
      cnt_cfg  <= '0;
      rdata    <= '0;
    end else begin
      if (wr_ctrl) sleep_en <= wdata[CTRL_EN_BIT];
      if (wr_ctrl && wdata[CTRL_DONE_BIT]) done <= 1'b0;
      if (set_done) done <= 1'b1;
      if (wr_wcnt) cnt_cfg <= wdata[CNT_W-1:0];
      rdata <= (addr == ADDR_CTRL) ? ctrl_word : DATA_W'(cnt_cfg);
    end
  end
endmodule

// File: rtl/dslp_wake_cnt.sv
module dslp_wake_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);
  logic [CNT_W:0] cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign hit     = (cnt_nxt == {1'b0, target});

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/dslp_fsm.sv
module dslp_fsm
  import dslp_pkg::*;
#(
  parameter int SHUT_CYC = 3,
  localparam int SD_W = $clog2(SHUT_CYC + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        req_low,
  input  logic        hit,
  output dslp_state_e state_q,
  output logic        cnt_clr,
  output logic        cnt_inc,
  output logic        wake_evt,
  output logic        gate_en
);
  dslp_state_e     state_n;
  logic [SD_W-1:0] sd_q;

  always_comb begin
    state_n = state_q;
    cnt_inc = 1'b0;
    case (state_q)
      ST_IDLE:     if (enable && req_low) state_n = ST_SHUTDOWN;
      ST_SHUTDOWN: if (sd_q == SD_W'(SHUT_CYC - 1)) state_n = ST_ASLEEP;
      ST_ASLEEP, ST_COUNTING: begin
        if (!req_low) begin
          cnt_inc = 1'b1;
          state_n = hit ? ST_AWAKE : ST_COUNTING;
        end
      end
      ST_AWAKE: begin
        if (!enable)      state_n = ST_IDLE;
        else if (req_low) state_n = ST_SHUTDOWN;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign cnt_clr  = (state_n == ST_SHUTDOWN) && (state_q != ST_SHUTDOWN);
  assign wake_evt = (state_n == ST_AWAKE) && (state_q != ST_AWAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sd_q    <= '0;
      gate_en <= 1'b1;
    end else begin
      state_q <= state_n;
      sd_q    <= (state_q == ST_SHUTDOWN) ? sd_q + SD_W'(1) : '0;
      gate_en <= !((state_n == ST_ASLEEP) || (state_n == ST_COUNTING));
    end
  end
endmodule

// File: rtl/dslp_wake_ctrl.sv
module dslp_wake_ctrl
  import dslp_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int SHUT_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_osc,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sleep_req_n,
  output logic              clk_gate_en,
  output logic              wake_done
);
  logic             req_sync;
  logic             req_low;
  logic             sleep_en;
  logic [CNT_W-1:0] cnt_cfg;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] wake_cnt_q;
  logic             hit;
  logic             cnt_clr;
  logic             cnt_inc;
  logic             wake_evt;
  dslp_state_e      state;

  dslp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk_osc), .rst(rst), .d(sleep_req_n), .q(req_sync)
  );
  assign req_low = !req_sync;

  dslp_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk_osc), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .set_done(wake_evt),
    .sleep_en(sleep_en), .done(wake_done), .cnt_cfg(cnt_cfg)
  );

  assign target = (cnt_cfg == '0) ? CNT_W'(1) : cnt_cfg;

  dslp_wake_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk_osc), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .target(target), .cnt_q(wake_cnt_q), .hit(hit)
  );

  dslp_fsm #(.SHUT_CYC(SHUT_CYC)) u_fsm (
    .clk(clk_osc), .rst(rst), .enable(sleep_en), .req_low(req_low),
    .hit(hit), .state_q(state), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .wake_evt(wake_evt), .gate_en(clk_gate_en)
  );
endmodule

// File: rtl/dslp_wake_chk.sv
module dslp_wake_chk
  import dslp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             gate,
  input logic             done,
  input dslp_state_e      state,
  input logic [CNT_W-1:0] cnt,
  input logic             req_low,
  input logic             enable
);
  assert_idle_when_disabled_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !enable) |=> (state == ST_IDLE));

  assert_gate_falls_from_shutdown_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(gate) |-> ($past(state) == ST_SHUTDOWN));

  assert_shutdown_completes_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHUTDOWN) |=> (state == ST_SHUTDOWN || state == ST_ASLEEP));

  assert_gate_off_while_waiting_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ASLEEP || state == ST_COUNTING) |-> !gate);

  assert_count_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNTING && req_low) |=> $stable(cnt));

  assert_done_with_wake_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> done);

  assert_disable_to_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AWAKE && !enable) |=> (state == ST_IDLE));
endmodule

bind dslp_wake_ctrl dslp_wake_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk_osc), .rst(rst), .gate(clk_gate_en), .done(wake_done),
  .state(state), .cnt(wake_cnt_q), .req_low(req_low), .enable(sleep_en)
);

// File: tb/dslp_wake_ctrl_test.sv
module dslp_wake_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk_osc = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr_en = 1'b0;
  logic          reg_addr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          sleep_req_n = 1'b1;
  logic          clk_gate_en;
  logic          wake_done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_osc = ~clk_osc;

  dslp_wake_ctrl uut (
    .clk_osc(clk_osc), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req_n(sleep_req_n),
    .clk_gate_en(clk_gate_en), .wake_done(wake_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    @(negedge clk_osc);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk_osc);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [DW-1:0] d);
    @(negedge clk_osc);
    reg_addr = a;
    @(posedge clk_osc); #1;
    d = reg_rdata;
  endtask

  task automatic pin(input logic v);
    @(negedge clk_osc);
    sleep_req_n = v;
  endtask

  // counts rising edges until clk_gate_en equals lvl; returns 0 if never seen
  task automatic edges_to(input logic lvl, output int n);
    n = 0;
    for (int i = 1; i <= 200; i++) begin
      @(posedge clk_osc); #1;
      if (clk_gate_en == lvl) begin n = i; break; end
    end
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    chk("R1 gate after reset", int'(clk_gate_en), 1);
    chk("R1 done after reset", int'(wake_done), 0);
    rd(1'b0, d); chk("R1 ctrl reads zero", int'(d), 0);
    rd(1'b1, d); chk("R1 count reads zero", int'(d), 0);
  endtask

  task automatic t_disabled;
    int low = 0;
    pin(1'b0);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk_osc); #1;
      if (!clk_gate_en) low++;
    end
    chk("R2 no gating while disabled", low, 0);
    pin(1'b1);
    repeat (3) @(posedge clk_osc);
  endtask

  task automatic t_basic;
    logic [DW-1:0] d;
    int n;
    wr(1'b1, 16'd5);
    wr(1'b0, 16'h0001);
    rd(1'b1, d); chk("R11 count readback", int'(d), 5);
    rd(1'b0, d); chk("R11 ctrl readback", int'(d), 1);
    pin(1'b0);
    edges_to(1'b0, n); chk("R3 gate falls on edge 6", n, 6);
    repeat (4) @(posedge clk_osc);
    pin(1'b1);
    edges_to(1'b1, n); chk("R5 gate rises on edge N+2", n, 7);
    chk("R8 done with gate rise", int'(wake_done), 1);
    rd(1'b0, d); chk("R8 done in ctrl bit1", int'(d), 3);
    wr(1'b0, 16'h0003);
    rd(1'b0, d); chk("R8 write one clears done", int'(d), 1);
  endtask

  task automatic t_short_release;
    int n;
    pin(1'b0);
    repeat (3) @(posedge clk_osc); #1;
    chk("R4 gate still on at edge 3", int'(clk_gate_en), 1);
    pin(1'b1);
    edges_to(1'b0, n); chk("R4 early release still gates", n, 3);
    edges_to(1'b1, n); chk("R5 wake after early release", n, 5);
    wr(1'b0, 16'h0003);
  endtask

  task automatic t_zero_count;
    int n;
    wr(1'b1, 16'd0);
    pin(1'b0);
    edges_to(1'b0, n); chk("R3 fall with zero count", n, 6);
    repeat (2) @(posedge clk_osc);
    pin(1'b1);
    edges_to(1'b1, n); chk("R6 zero count acts as one", n, 3);
    wr(1'b0, 16'h0003);
  endtask

  task automatic t_hold;
    int n;
    int high = 0;
    wr(1'b1, 16'd10);
    pin(1'b0);
    edges_to(1'b0, n); chk("R3 fall before hold test", n, 6);
    repeat (2) @(posedge clk_osc);
    pin(1'b1);
    repeat (4) @(posedge clk_osc);
    pin(1'b0);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk_osc); #1;
      if (clk_gate_en) high++;
    end
    chk("R7 gate off during hold", high, 0);
    pin(1'b1);
    edges_to(1'b1, n); chk("R7 count resumes not restarts", n, 8);
  endtask

  task automatic t_reenter;
    int n;
    chk("R9 done still set before reentry", int'(wake_done), 1);
    pin(1'b0);
    edges_to(1'b0, n); chk("R9 reentry gates clock", n, 6);
    pin(1'b1);
    edges_to(1'b1, n); chk("R9 wake after reentry", n, 12);
    wr(1'b0, 16'h0003);
  endtask

  task automatic t_disable_exit;
    logic [DW-1:0] d;
    int low = 0;
    wr(1'b0, 16'h0000);
    rd(1'b0, d); chk("R10 ctrl cleared", int'(d), 0);
    pin(1'b0);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk_osc); #1;
      if (!clk_gate_en) low++;
    end
    chk("R10 idle ignores request", low, 0);
    pin(1'b1);
  endtask

  initial begin
    repeat (4) @(posedge clk_osc);
    @(negedge clk_osc); rst = 1'b0;
    t_reset;
    t_disabled;
    t_basic;
    t_short_release;
    t_zero_count;
    t_hold;
    t_reenter;
    t_disable_exit;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_osc);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule